// File: doc/BRIEF.md
# Multi-Symbol Prefix-Code Stream Decoder

The block takes a compressed bitstream one byte per clock and turns it into symbol indices of a fixed canonical prefix code. Each output beat holds every complete codeword found in the buffered bits, up to a limit of eight. Only the bits of a codeword that is still unfinished stay behind, and they are joined to the next byte. The block does not drop to one symbol per cycle. A cycle that brings in eight bits made of short codewords empties them all in a single beat.

Incoming bits are taken most significant first. They are aligned behind the unconsumed bits of a 16-bit holding register. Each clock, a chain of eight single-codeword matchers walks through the window. The code table is fixed at elaboration through a parameter that gives the number of codewords of each length. The input side uses a valid/ready handshake. The output side holds a beat until the consumer takes it.

Top module: `huff_multi_decoder`

## Requirements
- R1: After reset is released, `out_valid` is low, `in_ready` is high and the holding register is empty, so no beat appears until bytes are accepted.
- R2: The code is canonical and read MSB first. Symbol 0 is `0`. Symbols 1 to 3 are the 4-bit values 8 to 10. Symbols 4 to 7 are the 5-bit values 22 to 25. Symbols 8 to 11 are the 6-bit values 52 to 55. Symbols 12 to 27 are the 7-bit values 112 to 127. The decoded symbols leave the block in stream order.
- R3: All complete codewords in the window (up to eight) are emitted in the same beat. The first symbol sits in `out_syms[6:0]` and symbol k in `out_syms[7k+6:7k]`. Fields at or above `out_count` are zero.
- R4: The bits of an unfinished trailing codeword are kept and placed directly in front of the next accepted byte.
- R5: When more than eight complete codewords are buffered, one beat carries eight of them and the rest follow in the next beat.
- R6: `out_left` equals the number of buffered bits not consumed by the beat. When `out_count` is below eight, this is less than 7.
- R7: `in_ready` is high exactly when the bits left after this cycle's decode plus 8 do not exceed 16. A byte is taken only when `in_valid` and `in_ready` are both high.
- R8: While `out_valid` is high and `out_ready` is low, the beat stays unchanged and no bits are consumed.
- R9: `out_valid` rises only for a beat with at least one symbol, and `out_count` is then between 1 and 8.
- R10: A byte accepted at one clock edge is decoded into the beat that is visible after the next edge, provided the output slot is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Compressed byte present |
| in_ready | output | 1 | Block can take the byte this cycle |
| in_data | input | 8 | Compressed byte, MSB first |
| out_valid | output | 1 | Beat of decoded symbols present |
| out_ready | input | 1 | Consumer takes the beat |
| out_count | output | 4 | Number of symbols in the beat |
| out_syms | output | 56 | Eight 7-bit symbol fields, first symbol lowest |
| out_left | output | 5 | Buffered bits left after this beat |

## Verification
The assertions check several rules on every cycle. The fill level never passes 16. Bits below the valid region stay clear. A stalled beat stays frozen. A beat always carries 1 to 8 symbols, and a beat below eight symbols leaves less than one codeword behind. Other behaviour can only be shown by the bench's scenarios: the table mapping, the symbol order, joining leftover bits to the next byte, splitting a run of more than eight codewords across beats, and refusing a byte when the register is full. The bench shows these with a behavioural bit-queue model, directed byte patterns, and a long random stream with random stalls on both sides.

// File: rtl/huff_pkg.sv
package huff_pkg;

  // Longest codeword the matcher handles; the table type is sized by it.
  localparam int HUFF_MAX_LEN = 7;
  localparam int HUFF_LEN_W   = $clog2(HUFF_MAX_LEN + 1);

  // Element i holds the number of codewords of length i+1.
  typedef int unsigned huff_len_cnt_t [HUFF_MAX_LEN];

  // First canonical code value of a given length.
  function automatic int unsigned huff_first_code(huff_len_cnt_t cnt, int len);
    int unsigned code;
    code = 0;
    for (int l = 1; l <= HUFF_MAX_LEN; l++) begin
      if (l == len) return code;
      code = (code + cnt[l-1]) << 1;
    end
    return code;
  endfunction

  // Symbol index given to the first code of a given length.
  function automatic int unsigned huff_base_sym(huff_len_cnt_t cnt, int len);
    int unsigned base;
    base = 0;
    for (int l = 1; l < len; l++) base = base + cnt[l-1];
    return base;
  endfunction

endpackage

// File: rtl/huff_code_match.sv
module huff_code_match
  import huff_pkg::*;
#(
  parameter huff_len_cnt_t LEN_COUNT = '{1, 0, 0, 3, 4, 4, 16},
  parameter int SYM_W   = 7,
  parameter int AVAIL_W = 5
) (
  input  logic [HUFF_MAX_LEN-1:0] peek,
  input  logic [AVAIL_W-1:0]      avail,
  output logic                    hit,
  output logic [HUFF_LEN_W-1:0]   len,
  output logic [SYM_W-1:0]        sym
);

  logic [HUFF_MAX_LEN-1:0] is_len;
  logic [SYM_W-1:0]        sym_at [HUFF_MAX_LEN];

  // One range compare per code length.
  for (genvar g = 0; g < HUFF_MAX_LEN; g++) begin : g_len
    localparam int L = g + 1;
    localparam logic [HUFF_MAX_LEN:0] FIRST =
      (HUFF_MAX_LEN + 1)'(huff_first_code(LEN_COUNT, L));
    localparam logic [HUFF_MAX_LEN:0] COUNT = (HUFF_MAX_LEN + 1)'(LEN_COUNT[g]);
    localparam logic [SYM_W-1:0] BASE = SYM_W'(huff_base_sym(LEN_COUNT, L));
    logic [HUFF_MAX_LEN:0] offset;
    assign offset    = {1'b0, peek >> (HUFF_MAX_LEN - L)} - FIRST;
    assign is_len[g] = offset < COUNT;
    assign sym_at[g] = BASE + SYM_W'(offset);
  end

  // The shortest matching length wins; a prefix-free table has only one.
  always_comb begin
    len = '0;
    sym = '0;
    for (int i = HUFF_MAX_LEN - 1; i >= 0; i--) begin
      if (is_len[i]) begin
        len = HUFF_LEN_W'(i + 1);
        sym = sym_at[i];
      end
    end
    hit = (|is_len) && (avail >= AVAIL_W'(len));
  end

endmodule

// File: rtl/huff_decode_chain.sv
module huff_decode_chain
  import huff_pkg::*;
#(
  parameter huff_len_cnt_t LEN_COUNT = '{1, 0, 0, 3, 4, 4, 16},
  parameter int BUF_W   = 16,
  parameter int MAX_SYM = 8,
  parameter int SYM_W   = 7,
  parameter int CNT_W   = 5,
  parameter int NUM_W   = 4
) (
  input  logic [BUF_W-1:0]         win,
  input  logic [CNT_W-1:0]         avail,
  input  logic                     enable,
  output logic [NUM_W-1:0]         n_sym,
  output logic [CNT_W-1:0]         used,
  output logic [MAX_SYM*SYM_W-1:0] syms
);

  logic [BUF_W-1:0]   stg_win  [MAX_SYM+1];
  logic [CNT_W-1:0]   stg_rem  [MAX_SYM+1];
  logic [MAX_SYM:0]   stg_live;
  logic [MAX_SYM-1:0] take;

  assign stg_win[0]  = win;
  assign stg_rem[0]  = avail;
  assign stg_live[0] = enable;

  // Stage k peels codeword k off the top of the window.
  for (genvar k = 0; k < MAX_SYM; k++) begin : g_stage
    logic                  hit_k;
    logic [HUFF_LEN_W-1:0] len_k;
    logic [SYM_W-1:0]      sym_k;

    huff_code_match #(
      .LEN_COUNT(LEN_COUNT),
      .SYM_W    (SYM_W),
      .AVAIL_W  (CNT_W)
    ) u_match (
      .peek (stg_win[k][BUF_W-1 -: HUFF_MAX_LEN]),
      .avail(stg_rem[k]),
      .hit  (hit_k),
      .len  (len_k),
      .sym  (sym_k)
    );

    assign take[k]       = stg_live[k] && hit_k;
    assign stg_live[k+1] = take[k];
    assign stg_win[k+1]  = take[k] ? (stg_win[k] << len_k) : stg_win[k];
    assign stg_rem[k+1]  = take[k] ? (stg_rem[k] - CNT_W'(len_k)) : stg_rem[k];
    assign syms[k*SYM_W +: SYM_W] = take[k] ? sym_k : '0;
  end

  assign n_sym = NUM_W'($countones(take));
  assign used  = avail - stg_rem[MAX_SYM];

endmodule

// File: rtl/huff_bit_buffer.sv
module huff_bit_buffer #(
  parameter int BUF_W = 16,
  parameter int IN_W  = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [IN_W-1:0]  data,
  input  logic [CNT_W-1:0] used,
  output logic [BUF_W-1:0] win,
  output logic [CNT_W-1:0] avail,
  output logic             room
);

  logic [BUF_W-1:0] bits_q, bits_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, rem;
  logic             upd;

  // Next state: drop consumed bits, then place the new byte right behind
  // the remaining ones.
  always_comb begin
    rem    = cnt_q - used;
    room   = ({1'b0, rem} + (CNT_W + 1)'(IN_W)) <= (CNT_W + 1)'(BUF_W);
    bits_d = bits_q << used;
    cnt_d  = rem;
    if (load) begin
      bits_d = bits_d | ((BUF_W'(data) << (BUF_W - IN_W)) >> rem);
      cnt_d  = rem + CNT_W'(IN_W);
    end
    upd = load || (used != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      bits_q <= bits_d;
      cnt_q  <= cnt_d;
    end
  end

  assign win   = bits_q;
  assign avail = cnt_q;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BUF_W)) else $error("fill level above capacity"); // R7
  AST_TAIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bits_q << cnt_q) == '0) else $error("stale bits below valid region"); // R4
  AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used <= cnt_q) else $error("consumed more bits than buffered"); // R6
  AST_ACCEPT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q >= CNT_W'(IN_W)) else $error("accepted byte missing"); // R7

endmodule

// File: rtl/huff_multi_decoder.sv
module huff_multi_decoder
  import huff_pkg::*;
#(
  parameter int IN_W    = 8,
  parameter int BUF_W   = 16,
  parameter int MAX_SYM = 8,
  parameter int SYM_W   = 7,
  parameter huff_len_cnt_t LEN_COUNT = '{1, 0, 0, 3, 4, 4, 16},
  localparam int CNT_W = $clog2(BUF_W + 1),
  localparam int NUM_W = $clog2(MAX_SYM + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [IN_W-1:0]          in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NUM_W-1:0]         out_count,
  output logic [MAX_SYM*SYM_W-1:0] out_syms,
  output logic [CNT_W-1:0]         out_left
);

  // Reset: asserted at once, released two edges later.
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic                     slot_free, load;
  logic [BUF_W-1:0]         buf_win;
  logic [CNT_W-1:0]         buf_avail, dec_used;
  logic                     buf_room;
  logic [NUM_W-1:0]         dec_n;
  logic [MAX_SYM*SYM_W-1:0] dec_syms;

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = buf_room;
  assign load      = in_valid && buf_room;

  huff_bit_buffer #(
    .BUF_W(BUF_W),
    .IN_W (IN_W),
    .CNT_W(CNT_W)
  ) u_buffer (
    .clk  (clk),
    .rst_n(rst_core_n),
    .load (load),
    .data (in_data),
    .used (dec_used),
    .win  (buf_win),
    .avail(buf_avail),
    .room (buf_room)
  );

  huff_decode_chain #(
    .LEN_COUNT(LEN_COUNT),
    .BUF_W    (BUF_W),
    .MAX_SYM  (MAX_SYM),
    .SYM_W    (SYM_W),
    .CNT_W    (CNT_W),
    .NUM_W    (NUM_W)
  ) u_chain (
    .win   (buf_win),
    .avail (buf_avail),
    .enable(slot_free),
    .n_sym (dec_n),
    .used  (dec_used),
    .syms  (dec_syms)
  );

  // Output beat register: next state, then register with enable.
  logic                     ov_d;
  logic [NUM_W-1:0]         count_d;
  logic [MAX_SYM*SYM_W-1:0] syms_d;
  logic [CNT_W-1:0]         left_d;

  always_comb begin
    ov_d    = dec_n != '0;
    count_d = dec_n;
    syms_d  = dec_syms;
    left_d  = buf_avail - dec_used;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      out_valid <= 1'b0;
      out_count <= '0;
      out_syms  <= '0;
      out_left  <= '0;
    end else if (slot_free) begin
      out_valid <= ov_d;
      out_count <= count_d;
      out_syms  <= syms_d;
      out_left  <= left_d;
    end
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_core_n)
    out_valid |-> (out_count != '0) && (out_count <= NUM_W'(MAX_SYM)))
    else $error("beat symbol count out of range"); // R9
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_count)
      && $stable(out_syms) && $stable(out_left))
    else $error("stalled beat changed"); // R8
  AST_PARTIAL_LEFT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && (out_count < NUM_W'(MAX_SYM))) |-> out_left < CNT_W'(HUFF_MAX_LEN))
    else $error("short beat left a full codeword behind"); // R6
  AST_STALL_KEEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (out_valid && !out_ready && !in_valid) |=> $stable(buf_avail))
    else $error("bits consumed while output stalled"); // R8

endmodule

// File: tb/huff_multi_decoder_test.sv
`timescale 1ns/1ps
module huff_multi_decoder_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        out_valid;
  logic        out_ready;
  logic [3:0]  out_count;
  logic [55:0] out_syms;
  logic [4:0]  out_left;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  huff_multi_decoder uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_count(out_count), .out_syms(out_syms), .out_left(out_left)
  );

  // Code table from R2, written behaviourally.
  function automatic int code_len(int s);
    if (s == 0) return 1;
    if (s <= 3) return 4;
    if (s <= 7) return 5;
    if (s <= 11) return 6;
    return 7;
  endfunction

  function automatic int code_val(int s);
    if (s == 0) return 0;
    if (s <= 3) return 8 + s - 1;
    if (s <= 7) return 22 + s - 4;
    if (s <= 11) return 52 + s - 8;
    return 112 + s - 12;
  endfunction

  // Reference model state.
  bit mq[$];
  bit m_ov = 1'b0;
  int m_cnt = 0;
  int m_syms[8];
  int m_left = 0;
  int got[$];
  int sent[$];

  function automatic bit match_at(int idx, output int len, output int sym);
    for (int l = 1; l <= 7; l++) begin
      if (idx + l <= mq.size()) begin
        int v = 0;
        for (int i = 0; i < l; i++) v = v * 2 + int'(mq[idx+i]);
        for (int s = 0; s < 28; s++) begin
          if (code_len(s) == l && code_val(s) == v) begin
            len = l; sym = s; return 1'b1;
          end
        end
      end
    end
    len = 0; sym = 0;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, compare, advance the model.
  task automatic step(input bit iv, input logic [7:0] d, input bit ordy, output bit acc);
    bit slot;
    int n, idx, len, sym, r;
    int tmp[8];
    bit rdy;
    in_valid = iv; in_data = d; out_ready = ordy;
    #1;
    chk(out_valid === m_ov, "R8 out_valid", int'(out_valid), int'(m_ov));
    if (m_ov && out_valid) begin
      chk(int'(out_count) == m_cnt, "R9 out_count", int'(out_count), m_cnt);
      for (int k = 0; k < 8; k++)
        chk(int'(out_syms[k*7 +: 7]) == (k < m_cnt ? m_syms[k] : 0), "R3 symbol field",
            int'(out_syms[k*7 +: 7]), (k < m_cnt ? m_syms[k] : 0));
      chk(int'(out_left) == m_left, "R6 out_left", int'(out_left), m_left);
    end
    if (out_valid && ordy)
      for (int k = 0; k < int'(out_count); k++) got.push_back(int'(out_syms[k*7 +: 7]));
    slot = !m_ov || ordy;
    n = 0; idx = 0;
    for (int k = 0; k < 8; k++) tmp[k] = 0;
    if (slot) begin
      while (n < 8 && match_at(idx, len, sym)) begin
        tmp[n] = sym; idx += len; n++;
      end
    end
    r = mq.size() - idx;
    rdy = (r + 8 <= 16);
    chk(in_ready === rdy, "R7 in_ready", int'(in_ready), int'(rdy));
    acc = iv && in_ready;
    @(posedge clk);
    if (slot) begin
      m_ov = (n > 0); m_cnt = n; m_left = r;
      for (int k = 0; k < 8; k++) m_syms[k] = tmp[k];
      repeat (idx) void'(mq.pop_front());
    end
    if (acc) for (int i = 7; i >= 0; i--) mq.push_back(d[i]);
    @(negedge clk);
  endtask

  task automatic expect_beat(input bit ev, input int ec, input int es[8], input int el,
                             input string tag);
    chk(out_valid === ev, {tag, " valid"}, int'(out_valid), int'(ev));
    if (ev) begin
      chk(int'(out_count) == ec, {tag, " count"}, int'(out_count), ec);
      for (int k = 0; k < 8; k++)
        chk(int'(out_syms[k*7 +: 7]) == es[k], {tag, " field"}, int'(out_syms[k*7 +: 7]), es[k]);
      chk(int'(out_left) == el, {tag, " left"}, int'(out_left), el);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit acc;
    bit enc[$];
    int nbytes, bi;
    int zeros8[8] = '{0, 0, 0, 0, 0, 0, 0, 0};
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: idle state after reset
    #1;
    chk(out_valid === 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // R3: 0,0,0 then 10110 in one byte
    step(1'b1, 8'h16, 1'b1, acc);
    step(1'b0, 8'h00, 1'b0, acc);
    expect_beat(1'b1, 4, '{0, 0, 0, 4, 0, 0, 0, 0}, 0, "R3 multi-symbol byte");

    // R8/R7/R5: stall the output and fill the register with zero codes
    step(1'b1, 8'h00, 1'b0, acc);
    step(1'b1, 8'h00, 1'b0, acc);
    #1;
    chk(in_ready === 1'b0, "R7 full register refuses", int'(in_ready), 0);
    expect_beat(1'b1, 4, '{0, 0, 0, 4, 0, 0, 0, 0}, 0, "R8 stalled beat held");
    step(1'b1, 8'hFF, 1'b0, acc);
    chk(acc == 1'b0, "R7 byte not taken", int'(acc), 0);
    step(1'b0, 8'h00, 1'b1, acc);
    expect_beat(1'b1, 8, zeros8, 8, "R5 first capped beat");
    step(1'b0, 8'h00, 1'b1, acc);
    expect_beat(1'b1, 8, zeros8, 0, "R5 second capped beat");
    step(1'b0, 8'h00, 1'b1, acc);
    expect_beat(1'b0, 0, zeros8, 0, "R9 no beat when empty");

    // R4/R10: 110100 + '11' carried, joined with 10000000
    step(1'b1, 8'hD3, 1'b1, acc);
    step(1'b1, 8'h80, 1'b1, acc);
    expect_beat(1'b1, 1, '{8, 0, 0, 0, 0, 0, 0, 0}, 2, "R10 beat one edge after accept");
    step(1'b0, 8'h00, 1'b1, acc);
    expect_beat(1'b1, 4, '{12, 0, 0, 0, 0, 0, 0, 0}, 0, "R4 leftover joined to next byte");
    step(1'b0, 8'h00, 1'b1, acc);

    // R2: random stream with random stalls, compared in order
    got.delete();
    for (int i = 0; i < 700; i++) begin
      int s = ($urandom % 2 == 0) ? 0 : int'($urandom % 28);
      sent.push_back(s);
      for (int b = code_len(s) - 1; b >= 0; b--) enc.push_back(code_val(s)[b]);
    end
    while (enc.size() % 8 != 0) begin
      sent.push_back(0);
      enc.push_back(1'b0);
    end
    nbytes = enc.size() / 8;
    bi = 0;
    while (bi < nbytes) begin
      logic [7:0] d;
      for (int i = 0; i < 8; i++) d[7-i] = enc[bi*8+i];
      step($urandom % 5 != 0, d, $urandom % 5 != 0, acc);
      if (acc) bi++;
    end
    repeat (40) step(1'b0, 8'h00, 1'b1, acc);
    chk(got.size() == sent.size(), "R2 decoded symbol total", got.size(), sent.size());
    for (int i = 0; i < sent.size() && i < got.size(); i++)
      chk(got[i] == sent[i], "R2 symbol order", got[i], sent[i]);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule